// File: doc/BRIEF.md
# Write-Through Cache Controller with External Tag and Data SRAM

This block is the control half of a direct-mapped first-level cache. The tag compare, the valid bits and the sequencing stay on chip, while the tags and data words live in a plain external SRAM. The SRAM has a combinational (flow-through) read port and a write port that lands on the clock edge. The processor side is a word-addressed request port with byte enables and a stall output. A request completes in any cycle where `cpu_req` is high and `cpu_stall` is low, and the processor holds its request steady while stalled.

Every store goes to memory through a one-entry write slot. Reads that miss refill a naturally aligned block of 1 to 32 words, one word at a time, over a request/valid read channel. Three run-time inputs shape the behaviour: the refill length, how a partial-word store treats a hit, and whether the missed word is forwarded while the rest of the block is still arriving. The cache size is a parameter, so instruction and data copies can be built at different sizes.

Top module: `wt_cache_ctrl`

## Requirements
- R1: A read whose index has its valid bit set and whose stored tag equals the upper address bits completes in the same cycle with no stall, returning the SRAM data word.
- R2: Every accepted store, hit or miss, appears on the memory write port from the next cycle with its address, data and byte enables, and is held there until `mem_wr_rdy` is seen high.
- R3: The refill length is 2^`cfg_len_log` words; codes 0 to 5 give 1 to 32 words, and codes 6 and 7 give 32. A refill starts at the block-aligned address (the miss address with its low log2(length) bits cleared) and reads ascending addresses.
- R4: A read miss raises the stall. With streaming off, the stall stays high until every word of the block has been fetched, and the returned word is the current memory contents.
- R5: With streaming on, the stall drops in the cycle the missed word arrives, with that word on `cpu_rdata`, while the rest of the block keeps filling. Any new request stalls until the fill ends.
- R6: Valid bits are kept per word, so after a refill only the fetched words hit, and a word outside the fetched block still misses.
- R7: A full-word store (all byte enables set) that hits rewrites the cached word, so a later read hits with the new data. A full-word store that misses leaves the cache unchanged, so a later read of that address misses.
- R8: A partial-word store that hits either clears that word's valid bit (`cfg_pw_rmw`=0, so the next read misses) or merges the enabled bytes into the cached word (`cfg_pw_rmw`=1, so the next read hits). Byte enable bit i selects data bits 8i+7 down to 8i.
- R9: Reset clears every valid bit, and so does any change of the effective refill length; the clear takes effect one cycle after the change.
- R10: A store stalls while the write slot is occupied and `mem_wr_rdy` is low.
- R11: No refill read is issued while a store is waiting in the write slot, so a read after a store to the same address returns the stored data. A refill read request holds its address steady until `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len_log | input | 3 | log2 of refill length (6, 7 clamp to 32 words) |
| cfg_stream | input | 1 | Forward the missed word early |
| cfg_pw_rmw | input | 1 | Partial store on hit: 0 invalidate, 1 merge |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | Request is a store |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_rdata | output | DATA_W | Read data |
| cpu_stall | output | 1 | Request not completing this cycle |
| sram_addr | output | IDX_W | SRAM word index |
| sram_we | output | 1 | SRAM write strobe |
| sram_wtag | output | ADDR_W-IDX_W | Tag to write |
| sram_wdata | output | DATA_W | Data word to write |
| sram_rtag | input | ADDR_W-IDX_W | Tag read at `sram_addr` |
| sram_rdata | input | DATA_W | Data read at `sram_addr` |
| mem_rd_req | output | 1 | Refill read request |
| mem_raddr | output | ADDR_W | Refill word address |
| mem_rvalid | input | 1 | Refill word valid |
| mem_rdata | input | DATA_W | Refill word |
| mem_wr_req | output | 1 | Write slot occupied |
| mem_waddr | output | ADDR_W | Write address |
| mem_wdata | output | DATA_W | Write data |
| mem_wbe | output | DATA_W/8 | Write byte enables |
| mem_wr_rdy | input | 1 | Memory accepts the write |

## Verification
The embedded assertions check the port-level rules on every cycle: a store reaches the write port one cycle after acceptance, a store stalls against a busy write port, refill reads never overlap a pending store and hold steady until answered, refill addresses climb by one, a tag hit never stalls, and a length change empties the valid bits. Other behaviour needs scenarios from the bench. These are the block alignment and the clamp of long lengths, the point at which streaming releases the stall, the per-word valid pattern after short refills, no allocation on a store miss, and the two partial-store policies. The bench shows them with hit/miss stall counts and fetch logs, and it checks every read of a long random run against a reference memory.

// File: rtl/wt_cache_ctrl.sv
module wt_cache_ctrl #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 8,
  parameter int LEN_LOG_MAX = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              cfg_len_log,
  input  logic                    cfg_stream,
  input  logic                    cfg_pw_rmw,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [DATA_W/8-1:0]     cpu_be,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    cpu_stall,
  output logic [IDX_W-1:0]        sram_addr,
  output logic                    sram_we,
  output logic [ADDR_W-IDX_W-1:0] sram_wtag,
  output logic [DATA_W-1:0]       sram_wdata,
  input  logic [ADDR_W-IDX_W-1:0] sram_rtag,
  input  logic [DATA_W-1:0]       sram_rdata,
  output logic                    mem_rd_req,
  output logic [ADDR_W-1:0]       mem_raddr,
  input  logic                    mem_rvalid,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    mem_wr_req,
  output logic [ADDR_W-1:0]       mem_waddr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic [DATA_W/8-1:0]     mem_wbe,
  input  logic                    mem_wr_rdy
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int NB    = DATA_W / 8;
  localparam int WORDS = 1 << IDX_W;
  localparam int CNT_W = LEN_LOG_MAX + 1;

  typedef enum logic {S_IDLE, S_FILL} st_t;
  st_t st;

  logic [WORDS-1:0]  vld;
  logic [ADDR_W-1:0] miss_addr, fill_base, wb_addr;
  logic [CNT_W-1:0]  cnt, last_q;
  logic [2:0]        len_q;
  logic              str_q, wb_valid;
  logic [DATA_W-1:0] wb_data, merged;
  logic [NB-1:0]     wb_be;

  wire [2:0]        eff_log  = (cfg_len_log > 3'(LEN_LOG_MAX)) ? 3'(LEN_LOG_MAX) : cfg_len_log;
  wire [CNT_W-1:0]  len_m1   = (CNT_W'(1) << eff_log) - CNT_W'(1);
  wire [ADDR_W-1:0] blk_mask = ~ADDR_W'(len_m1);
  wire [IDX_W-1:0]  cpu_idx  = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0]  cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
  wire [ADDR_W-1:0] fill_addr = fill_base + ADDR_W'(cnt);
  wire idle    = (st == S_IDLE);
  wire hit     = vld[cpu_idx] && (sram_rtag == cpu_tag);
  wire wb_free = !wb_valid || mem_wr_rdy;
  wire st_acc  = idle && cpu_req && cpu_we && wb_free;
  wire full    = &cpu_be;
  wire fill_rv = !idle && mem_rd_req && mem_rvalid;
  wire deliver = fill_rv && str_q && (fill_addr == miss_addr);

  always_comb begin
    merged = sram_rdata;
    for (int b = 0; b < NB; b++)
      if (cpu_be[b]) merged[8*b +: 8] = cpu_wdata[8*b +: 8];
  end

  assign cpu_stall  = cpu_req && (idle ? (cpu_we ? !wb_free : !hit) : (cpu_we || !deliver));
  assign cpu_rdata  = idle ? sram_rdata : mem_rdata;
  assign sram_addr  = idle ? cpu_idx : fill_addr[IDX_W-1:0];
  assign sram_wtag  = idle ? cpu_tag : fill_addr[ADDR_W-1:IDX_W];
  assign sram_wdata = idle ? merged : mem_rdata;
  assign sram_we    = idle ? (st_acc && hit && (full || cfg_pw_rmw)) : fill_rv;
  assign mem_rd_req = !idle && !wb_valid;
  assign mem_raddr  = fill_addr;
  assign mem_wr_req = wb_valid;
  assign mem_waddr  = wb_addr;
  assign mem_wdata  = wb_data;
  assign mem_wbe    = wb_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; vld <= '0; wb_valid <= 1'b0; cnt <= '0; last_q <= '0;
      len_q <= '0; str_q <= 1'b0; miss_addr <= '0; fill_base <= '0;
      wb_addr <= '0; wb_data <= '0; wb_be <= '0;
    end else begin
      if (wb_valid && mem_wr_rdy) wb_valid <= 1'b0;
      if (st_acc) begin
        wb_valid <= 1'b1; wb_addr <= cpu_addr; wb_data <= cpu_wdata; wb_be <= cpu_be;
      end
      if (idle) begin
        if (cpu_req && !cpu_we && !hit) begin
          st <= S_FILL; miss_addr <= cpu_addr; fill_base <= cpu_addr & blk_mask;
          cnt <= '0; last_q <= len_m1; str_q <= cfg_stream;
        end
        if (st_acc && hit && !full && !cfg_pw_rmw) vld[cpu_idx] <= 1'b0;
      end else if (fill_rv) begin
        vld[fill_addr[IDX_W-1:0]] <= 1'b1;
        cnt <= cnt + CNT_W'(1);
        if (cnt == last_q) st <= S_IDLE;
      end
      if (eff_log != len_q) begin
        vld <= '0; len_q <= eff_log;
      end
    end
  end

  p_hit_no_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && idle && vld[sram_addr] && sram_rtag == cpu_addr[ADDR_W-1:IDX_W])
      |-> (!cpu_stall && cpu_rdata == sram_rdata));
  p_store_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && !cpu_stall)
      |=> (mem_wr_req && mem_waddr == $past(cpu_addr) && mem_wdata == $past(cpu_wdata)));
  p_fill_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_rv && cnt != last_q) |=> (mem_raddr == $past(mem_raddr) + ADDR_W'(1)));
  p_len_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_log != len_q) |=> (vld == '0));
  p_busy_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_we && mem_wr_req && !mem_wr_rdy) |-> cpu_stall);
  p_drain_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> !mem_wr_req);
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rvalid) |=> (mem_rd_req && $stable(mem_raddr)));
endmodule

// File: tb/tb_wt_cache_ctrl.sv
`timescale 1ns/1ps
module tb_wt_cache_ctrl;
  localparam int AW = 10, DW = 32, IW = 6, TW = AW - IW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0] cfg_len_log = 3'd0;
  logic cfg_stream = 1'b0, cfg_pw_rmw = 1'b0;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [3:0] cpu_be = 4'hF;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_stall;
  logic [IW-1:0] sram_addr;
  logic sram_we;
  logic [TW-1:0] sram_wtag, sram_rtag;
  logic [DW-1:0] sram_wdata, sram_rdata;
  logic mem_rd_req, mem_rvalid, mem_wr_req, mem_wr_rdy;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [DW-1:0] mem_rdata, mem_wdata;
  logic [3:0] mem_wbe;

  wt_cache_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW), .LEN_LOG_MAX(5)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_len_log(cfg_len_log), .cfg_stream(cfg_stream),
    .cfg_pw_rmw(cfg_pw_rmw), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_be(cpu_be),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .sram_addr(sram_addr), .sram_we(sram_we), .sram_wtag(sram_wtag), .sram_wdata(sram_wdata),
    .sram_rtag(sram_rtag), .sram_rdata(sram_rdata), .mem_rd_req(mem_rd_req),
    .mem_raddr(mem_raddr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_wr_req(mem_wr_req), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_wbe(mem_wbe), .mem_wr_rdy(mem_wr_rdy));

  logic [TW-1:0] tag_m [1<<IW];
  logic [DW-1:0] dat_m [1<<IW];
  assign sram_rtag  = tag_m[sram_addr];
  assign sram_rdata = dat_m[sram_addr];
  always @(posedge clk) if (sram_we) begin
    tag_m[sram_addr] <= sram_wtag; dat_m[sram_addr] <= sram_wdata;
  end

  logic [DW-1:0] mem [1<<AW];
  logic [DW-1:0] ref_mem [1<<AW];
  int lat = 0;
  bit hold_wr = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0; mem_rdata <= '0; mem_wr_rdy <= 1'b0; lat <= 0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_rd_req && !mem_rvalid) begin
        if (lat == 0) begin
          mem_rvalid <= 1'b1; mem_rdata <= mem[mem_raddr]; lat <= int'($urandom % 3);
        end else lat <= lat - 1;
      end
      if (mem_wr_req && mem_wr_rdy)
        for (int b = 0; b < 4; b++)
          if (mem_wbe[b]) mem[mem_waddr][8*b +: 8] <= mem_wdata[8*b +: 8];
      mem_wr_rdy <= !hold_wr && (($urandom % 4) != 0);
    end
  end

  int fetch_n = 0;
  logic [AW-1:0] flog [64];
  always @(posedge clk) if (rst_n && mem_rd_req && mem_rvalid) begin
    if (fetch_n < 64) flog[fetch_n] = mem_raddr;
    fetch_n = fetch_n + 1;
  end

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
    return r;
  endfunction

  task automatic op(input bit we, input int a, input logic [3:0] be, input logic [31:0] wd,
                    output logic [31:0] rd, output int st, output int fn);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_be = be; cpu_wdata = wd;
    fetch_n = 0; st = 0;
    #1;
    while (cpu_stall && st < 3000) begin st++; @(negedge clk); #1; end
    if (st >= 3000) chk(0, "watchdog op", 32'(st), 0);
    rd = cpu_rdata; fn = fetch_n;
    @(posedge clk); #1;
    cpu_req = 1'b0;
    if (we) ref_mem[a] = merge(ref_mem[a], wd, be);
  endtask

  task automatic set_cfg(input logic [2:0] l, input bit s, input bit r);
    @(negedge clk); cfg_len_log = l; cfg_stream = s; cfg_pw_rmw = r;
    @(negedge clk);
  endtask

  initial begin
    #900us;
    chk(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int st, fn;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1<<AW); i++) begin
      mem[i] = 32'(i) * 32'h9E3779B1 ^ 32'h5A5A0000; ref_mem[i] = mem[i];
    end
    for (int i = 0; i < (1<<IW); i++) begin tag_m[i] = '0; dat_m[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!cpu_stall && !mem_rd_req && !mem_wr_req, "R9 reset idle", {mem_rd_req, mem_wr_req}, 0);

    op(0, 5, 4'hF, 0, rd, st, fn);
    chk(st > 0, "R9 cold miss after reset", 32'(st), 1);
    chk(fn == 1 && rd == ref_mem[5], "R4 one-word refill", rd, ref_mem[5]);
    op(0, 5, 4'hF, 0, rd, st, fn);
    chk(st == 0 && rd == ref_mem[5], "R1 hit", 32'(st), 0);
    op(0, 4, 4'hF, 0, rd, st, fn);
    chk(st > 0, "R6 neighbour not fetched", 32'(st), 1);

    set_cfg(3'd2, 0, 0);
    op(0, 5, 4'hF, 0, rd, st, fn);
    chk(st > 0, "R9 length change clears", 32'(st), 1);
    op(0, 'h15, 4'hF, 0, rd, st, fn);
    chk(fn == 4, "R3 length four", 32'(fn), 4);
    chk(flog[0] == 'h14 && flog[3] == 'h17, "R3 aligned ascending", {flog[0], 6'd0, flog[3]}, 32'h0014_0017);
    op(0, 'h14, 4'hF, 0, rd, st, fn);
    op(0, 'h17, 4'hF, 0, rd, fn, fn);
    chk(st == 0 && fn == 0, "R6 block words valid", 32'(st), 0);
    op(0, 'h18, 4'hF, 0, rd, st, fn);
    chk(st > 0, "R6 next block misses", 32'(st), 1);

    set_cfg(3'd7, 0, 0);
    op(0, 'h23, 4'hF, 0, rd, st, fn);
    chk(fn == 32, "R3 clamp to 32", 32'(fn), 32);
    chk(flog[0] == 'h20 && flog[31] == 'h3F, "R3 32-word block", {flog[0], 6'd0, flog[31]}, 32'h0020_003F);

    set_cfg(3'd3, 1, 0);
    op(0, 'h4A, 4'hF, 0, rd, st, fn);
    chk(fn == 2 && rd == ref_mem['h4A], "R5 early forward", 32'(fn), 2);
    op(0, 'h4F, 4'hF, 0, rd, st, fn);
    chk(st > 0 && rd == ref_mem['h4F], "R5 stall until fill ends", rd, ref_mem['h4F]);
    set_cfg(3'd3, 0, 0);
    op(0, 'h52, 4'hF, 0, rd, st, fn);
    chk(fn == 8 && rd == ref_mem['h52], "R4 stall whole block", 32'(fn), 8);

    op(1, 'h52, 4'hF, 32'hDEADBEEF, rd, st, fn);
    op(0, 'h52, 4'hF, 0, rd, st, fn);
    chk(st == 0 && rd == 32'hDEADBEEF, "R7 store hit updates", rd, 32'hDEADBEEF);
    op(1, 'h60, 4'hF, 32'hCAFEF00D, rd, st, fn);
    op(0, 'h60, 4'hF, 0, rd, st, fn);
    chk(st > 0 && rd == 32'hCAFEF00D, "R7 store miss no allocate", 32'(st), 1);
    chk(mem['h60] == 32'hCAFEF00D, "R2 store reaches memory", mem['h60], 32'hCAFEF00D);

    op(1, 'h53, 4'h1, 32'h11223344, rd, st, fn);
    op(0, 'h53, 4'hF, 0, rd, st, fn);
    chk(st > 0 && rd == ref_mem['h53], "R8 invalidate policy", rd, ref_mem['h53]);
    set_cfg(3'd3, 0, 1);
    op(0, 'h54, 4'hF, 0, rd, st, fn);
    op(1, 'h54, 4'h6, 32'hA1B2C3D4, rd, st, fn);
    op(0, 'h54, 4'hF, 0, rd, st, fn);
    chk(st == 0 && rd == ref_mem['h54], "R8 merge policy", rd, ref_mem['h54]);

    repeat (10) @(negedge clk);
    hold_wr = 1'b1;
    @(negedge clk);
    op(1, 'h70, 4'hF, 32'h01010101, rd, st, fn);
    chk(st == 0, "R10 empty slot accepts", 32'(st), 0);
    fork begin repeat (6) @(negedge clk); hold_wr = 1'b0; end join_none
    op(1, 'h71, 4'hF, 32'h02020202, rd, st, fn);
    chk(st >= 4, "R10 busy slot stalls", 32'(st), 4);
    repeat (10) @(negedge clk);
    hold_wr = 1'b1;
    @(negedge clk);
    op(1, 'h72, 4'hF, 32'h0BADCAFE, rd, st, fn);
    fork begin repeat (5) @(negedge clk); hold_wr = 1'b0; end join_none
    op(0, 'h72, 4'hF, 0, rd, st, fn);
    chk(rd == 32'h0BADCAFE, "R11 read after pending store", rd, 32'h0BADCAFE);
    chk(mem['h71] == 32'h02020202, "R2 held store written", mem['h71], 32'h02020202);

    for (int i = 0; i < 400; i++) begin
      int a;
      bit w;
      logic [3:0] be;
      if (i % 50 == 0) set_cfg(3'($urandom % 8), 1'($urandom % 2), 1'($urandom % 2));
      a = int'($urandom % 128);
      w = ($urandom % 10) < 3;
      be = ($urandom % 2) ? 4'hF : 4'($urandom);
      op(w, a, be, $urandom, rd, st, fn);
      if (!w) chk(rd == ref_mem[a], "R4 random read data", rd, ref_mem[a]);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule